// File: doc/BRIEF.md
# Kernel-Weighted Colour Histogram Builder

This block turns a rectangular window of RGB pixels into a colour model for a kernel-based tracker. Each pixel falls into a bin chosen by the upper bits of its three colour channels. Instead of counting pixels, the block adds a spatial kernel weight to the bin. The weights arrive on their own stream, one per pixel and in the same order. When the whole window has been accepted, every bin is divided by the sum of all the weights. The result is a fixed-point fraction of the window's total weight.

Two models are held. The reference model describes the target, and it is built once when a window start arrives with the reference mode flag set. The candidate model is rebuilt each time a window start arrives with the flag clear, or when the feedback input asks for another iteration on the same frame. Both builds take pixels through the same input port. A build first clears a shared accumulator one bin per cycle. It then accepts exactly one window of pixel and weight pairs, and then normalises the bins one by one into the store of the model being built. Either store can be read at any time by bin number.

Top module: `kh_colour_model`

## Requirements
- R1: The bin number is the concatenation {R[7:5], G[7:5], B[7:5]}, using the top QB=3 bits of each 8-bit channel with red most significant. This gives 512 bins numbered 0 to 511.
- R2: After a build, bin b reads floor(S_b * 65536 / T). S_b is the sum of the weights of the pixels in bin b and T is the sum of all weights in the window. A bin that holds the whole weight (result 65536) reads 65535.
- R3: When the total weight of a window is zero, every bin of the model built from it reads 0.
- R4: A window start with mode_ref=1 rebuilds the reference store. A window start with mode_ref=0 rebuilds the candidate store. Neither kind of build changes what the other store reads.
- R5: A one-cycle iter_again pulse while idle starts a candidate rebuild that behaves exactly like a window start with mode_ref=0.
- R6: busy is 0 after reset and is 1 in the cycle after an accepted start. For the next 512 cycles the block clears the accumulator, and px_ready and kw_ready stay 0. No weight from an earlier build carries into the new one.
- R7: A pair is transferred on a clock edge where px_valid, kw_valid and the internal accept state are all true. px_ready equals accept&&kw_valid and kw_ready equals accept&&px_valid. A build transfers exactly 520 pairs (a 20 by 26 window) and accepts none after that.
- R8: Pixels that fall into the same bin on back-to-back or gapped transfers all add their weight, and no update is lost.
- R9: done is a one-cycle pulse after the last bin is written, and busy is 0 in that same cycle. A start or iter_again seen while busy is ignored.
- R10: rd_frac shows the bin rd_bin of the store chosen by rd_ref (1 = reference, 0 = candidate), one clock after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Start-of-window pulse, sampled while idle |
| mode_ref | input | 1 | With win_start: 1 builds reference, 0 builds candidate |
| iter_again | input | 1 | Feedback pulse: rebuild candidate for another iteration |
| px_valid | input | 1 | Pixel stream valid |
| px_ready | output | 1 | Pixel stream ready |
| px_r | input | 8 | Red channel |
| px_g | input | 8 | Green channel |
| px_b | input | 8 | Blue channel |
| kw_valid | input | 1 | Kernel weight stream valid |
| kw_ready | output | 1 | Kernel weight stream ready |
| kw_weight | input | 8 | Kernel weight for the paired pixel |
| rd_ref | input | 1 | Readout store select |
| rd_bin | input | 9 | Readout bin number |
| rd_frac | output | 16 | Normalised bin value, one cycle after the address |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle pulse at the end of a build |

## Verification
busy becomes due one clock after the start edge. The handshake stays closed for exactly 512 clocks after that edge and opens on the 513th. The bench samples one negative edge after each of these edges. The done time depends on how many bins are occupied, so the bench waits for done and then checks in that same sample that busy has fallen and that no extra pair was taken. One sample later it checks that done has dropped. Readout values are due one clock after the address: the bench sets the address on one negative edge and compares on the next against floor(S*65536/T), computed from its own list of pixels and weights.

// File: rtl/kh_pkg.sv
package kh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACCUM,
    ST_DRAIN,
    ST_NRD,
    ST_NCHK,
    ST_NDIV
  } kh_state_e;
endpackage

// File: rtl/kh_sdp_ram.sv
module kh_sdp_ram #(
  parameter int DW = 16,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kh_accum_pipe.sv
// Read-modify-write of one bin per accepted pixel. The read is issued at the
// accept edge and the sum is written one edge later; a write landing on the
// same edge as a read of that bin is forwarded.
module kh_accum_pipe #(
  parameter int AW = 9,
  parameter int SW = 18,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] take_addr,
  input  logic [WW-1:0] take_w,
  input  logic [SW-1:0] mem_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [SW-1:0] wr_data
);
  logic          p1_valid, last_valid;
  logic [AW-1:0] p1_addr, last_addr;
  logic [WW-1:0] p1_w;
  logic [SW-1:0] last_data, base;

  always_comb begin
    base    = (last_valid && last_addr == p1_addr) ? last_data : mem_q;
    wr_data = base + SW'(p1_w);
    wr_en   = p1_valid;
    wr_addr = p1_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_valid   <= 1'b0;
      last_valid <= 1'b0;
    end else begin
      p1_valid   <= take;
      last_valid <= p1_valid;
    end
    p1_addr   <= take_addr;
    p1_w      <= take_w;
    last_addr <= p1_addr;
    last_data <= wr_data;
  end
endmodule

// File: rtl/kh_frac_div.sv
// Restoring divider giving floor(num * 2^FW / den) for num <= den,
// saturated to FW bits. One quotient bit per cycle, FW+1 cycles.
module kh_frac_div #(
  parameter int NW = 18,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [FW-1:0] quo
);
  localparam int QW = FW + 1;
  localparam int CW = $clog2(QW + 1);

  logic [NW:0]   rem;
  logic [NW-1:0] den_q, diff;
  logic [QW-1:0] q, q_next;
  logic [CW-1:0] cnt;
  logic          run, ge;

  always_comb begin
    ge     = rem >= {1'b0, den_q};
    diff   = ge ? NW'(rem - {1'b0, den_q}) : rem[NW-1:0];
    q_next = {q[QW-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= {1'b0, num};
        den_q <= den;
        q     <= '0;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        rem <= {diff, 1'b0};
        q   <= q_next;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(QW - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
          quo  <= q_next[QW-1] ? {FW{1'b1}} : q_next[FW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/kh_colour_model.sv
module kh_colour_model
  import kh_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int QB     = 3,
  parameter int WT_W   = 8,
  parameter int WIN_W  = 20,
  parameter int WIN_H  = 26,
  parameter int FRAC_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                win_start,
  input  logic                mode_ref,
  input  logic                iter_again,
  input  logic                px_valid,
  output logic                px_ready,
  input  logic [CH_W-1:0]     px_r,
  input  logic [CH_W-1:0]     px_g,
  input  logic [CH_W-1:0]     px_b,
  input  logic                kw_valid,
  output logic                kw_ready,
  input  logic [WT_W-1:0]     kw_weight,
  input  logic                rd_ref,
  input  logic [3*QB-1:0]     rd_bin,
  output logic [FRAC_W-1:0]   rd_frac,
  output logic                busy,
  output logic                done
);
  localparam int BIN_AW = 3 * QB;
  localparam int NPIX   = WIN_W * WIN_H;
  localparam int CNT_W  = $clog2(NPIX + 1);
  localparam int SUM_W  = WT_W + $clog2(NPIX + 1);

  kh_state_e         state;
  logic [BIN_AW-1:0] idx, pix_bin;
  logic [CNT_W-1:0]  pcnt;
  logic [SUM_W-1:0]  total, acc_q, acc_wdata, pipe_wdata;
  logic [BIN_AW-1:0] acc_waddr, acc_raddr, pipe_waddr;
  logic              acc_we, pipe_we, accepting, take, build_ref, rd_sel_q;
  logic              zero_bin, nwe, div_go, div_done, adv;
  logic [FRAC_W-1:0] nwdata, div_quo;
  logic [FRAC_W-1:0] norm_q [2];
  logic              unused_low_bits;

  assign unused_low_bits = ^{px_r[CH_W-QB-1:0], px_g[CH_W-QB-1:0], px_b[CH_W-QB-1:0]};

  always_comb begin
    pix_bin   = {px_r[CH_W-1 -: QB], px_g[CH_W-1 -: QB], px_b[CH_W-1 -: QB]};
    accepting = (state == ST_ACCUM);
    px_ready  = accepting && kw_valid;
    kw_ready  = accepting && px_valid;
    take      = accepting && px_valid && kw_valid;
    acc_we    = (state == ST_CLEAR) || pipe_we;
    acc_waddr = (state == ST_CLEAR) ? idx : pipe_waddr;
    acc_wdata = (state == ST_CLEAR) ? '0 : pipe_wdata;
    acc_raddr = accepting ? pix_bin : idx;
    zero_bin  = (acc_q == '0) || (total == '0);
    div_go    = (state == ST_NCHK) && !zero_bin;
    adv       = ((state == ST_NCHK) && zero_bin) || ((state == ST_NDIV) && div_done);
    nwe       = adv;
    nwdata    = (state == ST_NDIV) ? div_quo : '0;
    rd_frac   = rd_sel_q ? norm_q[0] : norm_q[1];
  end

  kh_sdp_ram #(.DW(SUM_W), .AW(BIN_AW)) u_acc_ram (
    .clk(clk), .we(acc_we), .waddr(acc_waddr), .wdata(acc_wdata),
    .raddr(acc_raddr), .rdata(acc_q)
  );

  kh_accum_pipe #(.AW(BIN_AW), .SW(SUM_W), .WW(WT_W)) u_pipe (
    .clk(clk), .rst(rst), .take(take), .take_addr(pix_bin), .take_w(kw_weight),
    .mem_q(acc_q), .wr_en(pipe_we), .wr_addr(pipe_waddr), .wr_data(pipe_wdata)
  );

  kh_frac_div #(.NW(SUM_W), .FW(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .start(div_go), .num(acc_q), .den(total),
    .done(div_done), .quo(div_quo)
  );

  // Store 0 holds the reference model, store 1 the candidate model.
  for (genvar g = 0; g < 2; g++) begin : g_store
    kh_sdp_ram #(.DW(FRAC_W), .AW(BIN_AW)) u_norm_ram (
      .clk(clk), .we(nwe && (build_ref == (g == 0))), .waddr(idx), .wdata(nwdata),
      .raddr(rd_bin), .rdata(norm_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      pcnt      <= '0;
      total     <= '0;
      build_ref <= 1'b0;
      rd_sel_q  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_sel_q <= rd_ref;
      case (state)
        ST_IDLE: if (win_start || iter_again) begin
          build_ref <= win_start && mode_ref;
          busy      <= 1'b1;
          idx       <= '0;
          pcnt      <= '0;
          total     <= '0;
          state     <= ST_CLEAR;
        end
        ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == {BIN_AW{1'b1}}) state <= ST_ACCUM;
        end
        ST_ACCUM: if (take) begin
          total <= total + SUM_W'(kw_weight);
          pcnt  <= pcnt + 1'b1;
          if (pcnt == CNT_W'(NPIX - 1)) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_NRD;
        ST_NRD:   state <= ST_NCHK;
        ST_NCHK:  if (!zero_bin) state <= ST_NDIV;
        default: ;
      endcase
      if (adv) begin
        if (idx == {BIN_AW{1'b1}}) begin
          done  <= 1'b1;
          busy  <= 1'b0;
          idx   <= '0;
          state <= ST_IDLE;
        end else begin
          idx   <= idx + 1'b1;
          state <= ST_NRD;
        end
      end
    end
  end
endmodule

// File: rtl/kh_colour_model_chk.sv
module kh_colour_model_chk (
  input logic clk,
  input logic rst,
  input logic win_start,
  input logic iter_again,
  input logic px_valid,
  input logic kw_valid,
  input logic px_ready,
  input logic kw_ready,
  input logic busy,
  input logic done
);
  p_ready_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (px_ready || kw_ready) |-> busy);

  p_clear_blocks_input_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!px_ready && !kw_ready));

  p_start_sets_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && (win_start || iter_again)) |=> busy);

  p_join_matched_r7: assert property (@(posedge clk) disable iff (rst)
    (px_valid && kw_valid) |-> (px_ready == kw_ready));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind kh_colour_model kh_colour_model_chk u_chk (
  .clk(clk), .rst(rst), .win_start(win_start), .iter_again(iter_again),
  .px_valid(px_valid), .kw_valid(kw_valid), .px_ready(px_ready),
  .kw_ready(kw_ready), .busy(busy), .done(done)
);

// File: tb/kh_colour_model_bench.sv
module kh_colour_model_bench;
  localparam int NBINS = 512;
  localparam int NPIX  = 520;

  logic clk = 1'b0, rst = 1'b1;
  logic win_start = 0, mode_ref = 0, iter_again = 0;
  logic px_valid = 0, kw_valid = 0, rd_ref = 0;
  logic px_ready, kw_ready, busy, done;
  logic [7:0] px_r = 0, px_g = 0, px_b = 0, kw_weight = 0;
  logic [8:0] rd_bin = 0;
  logic [15:0] rd_frac;

  int checks = 0, failures = 0;
  int pr[NPIX], pg[NPIX], pb[NPIX], pw[NPIX];
  int e_ref[NBINS], e_cand[NBINS], tmp[NBINS];

  always #5 clk = ~clk;

  kh_colour_model u_kh_colour_model (
    .clk(clk), .rst(rst), .win_start(win_start), .mode_ref(mode_ref),
    .iter_again(iter_again), .px_valid(px_valid), .px_ready(px_ready),
    .px_r(px_r), .px_g(px_g), .px_b(px_b), .kw_valid(kw_valid),
    .kw_ready(kw_ready), .kw_weight(kw_weight), .rd_ref(rd_ref),
    .rd_bin(rd_bin), .rd_frac(rd_frac), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock monitor of the handshake and done behaviour (R7, R9)
  logic done_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy || !(px_ready || kw_ready), "R7 ready while idle", px_ready, 0);
      chk(!(done && busy), "R9 busy with done", busy, 0);
      chk(!(done && done_prev), "R9 done longer than one cycle", done, 0);
      done_prev = done;
    end
  end

  function automatic int bin_of(int r, int g, int b);
    return ((r >> 5) << 6) | ((g >> 5) << 3) | (b >> 5);
  endfunction

  function automatic int kernel_w(int p);
    int dx = 2 * (p % 20) - 19;
    int dy = 2 * (p / 20) - 25;
    int w = 255 - (255 * dx * dx) / 400 - (255 * dy * dy) / 676;
    return (w < 0) ? 0 : w;
  endfunction

  task automatic gen(input int kind, input int seed);
    int unsigned s = seed;
    for (int i = 0; i < NPIX; i++) begin
      if (kind == 2) begin
        pr[i] = 200; pg[i] = 17; pb[i] = 99;
      end else if (kind == 1 && (i % 4) != 0) begin
        pr[i] = pr[i-1]; pg[i] = pg[i-1]; pb[i] = pb[i-1];
      end else begin
        s = s * 1103515245 + 12345; pr[i] = (s >> 16) & 255;
        s = s * 1103515245 + 12345; pg[i] = (s >> 16) & 255;
        s = s * 1103515245 + 12345; pb[i] = (s >> 16) & 255;
      end
      pw[i] = (kind == 3) ? 0 : kernel_w(i);
    end
  endtask

  task automatic compute();
    longint sums[NBINS];
    longint tot = 0, v;
    for (int b = 0; b < NBINS; b++) sums[b] = 0;
    for (int i = 0; i < NPIX; i++) begin
      sums[bin_of(pr[i], pg[i], pb[i])] += pw[i];
      tot += pw[i];
    end
    for (int b = 0; b < NBINS; b++) begin
      v = (tot == 0) ? 0 : (sums[b] << 16) / tot;
      tmp[b] = (v > 65535) ? 65535 : int'(v);
    end
  endtask

  task automatic run_build(input bit use_iter, input bit ref_mode, input bit gaps,
                           input bit inject);
    int bad = 0, idx = 0, cyc = 0, stall = 0, extra = 0, n = 0;
    @(negedge clk);
    px_valid = 0; kw_valid = 0;
    if (use_iter) iter_again = 1;
    else begin win_start = 1; mode_ref = ref_mode; end
    @(negedge clk);
    win_start = 0; iter_again = 0; mode_ref = 0;
    chk(busy == 1, "R6 busy after start", busy, 1);
    px_valid = 1; kw_valid = 1;
    px_r = 8'(pr[0]); px_g = 8'(pg[0]); px_b = 8'(pb[0]); kw_weight = 8'(pw[0]);
    for (int i = 0; i < NBINS; i++) begin
      #1; if (px_ready || kw_ready) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6 ready during clear", bad, 0);
    #1; chk(px_ready == 1, "R6 ready after clear", px_ready, 1);
    while (idx < NPIX) begin
      px_valid = !(gaps && (cyc % 3 == 2));
      kw_valid = !(gaps && (cyc % 5 == 4));
      px_r = 8'(pr[idx]); px_g = 8'(pg[idx]); px_b = 8'(pb[idx]);
      kw_weight = 8'(pw[idx]);
      win_start = inject && idx >= 100 && idx < 103;
      mode_ref = win_start;
      #1;
      if (px_valid && kw_valid) begin
        if (px_ready) idx++; else stall++;
      end
      @(negedge clk);
      cyc++;
    end
    win_start = 0; mode_ref = 0;
    px_valid = 1; kw_valid = 1;
    px_r = 0; px_g = 0; px_b = 0; kw_weight = 8'd77;
    while (!done && n < 30000) begin
      #1; if (px_ready || kw_ready) extra++;
      @(negedge clk);
      n++;
    end
    chk(stall == 0, "R7 stall with both valid", stall, 0);
    chk(done == 1, "R9 done seen", done, 1);
    chk(busy == 0, "R9 busy low at done", busy, 0);
    chk(extra == 0, "R7 accept beyond window", extra, 0);
    @(negedge clk);
    chk(done == 0, "R9 done pulse width", done, 0);
    px_valid = 0; kw_valid = 0;
  endtask

  // Readout sampled one clock after the address (R10)
  task automatic sweep(input bit sel, ref int exp[NBINS], input string req);
    for (int b = 0; b < NBINS; b++) begin
      @(negedge clk);
      rd_ref = sel; rd_bin = 9'(b);
      @(negedge clk);
      chk(rd_frac == exp[b], $sformatf("%s R10 bin %0d", req, b), rd_frac, exp[b]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R6 reset busy", busy, 0);
    chk(done == 0, "R9 reset done", done, 0);
    chk(px_ready == 0 && kw_ready == 0, "R7 reset ready", px_ready, 0);

    // Reference build, random colours
    gen(0, 11); compute(); e_ref = tmp;
    run_build(0, 1, 0, 0);
    sweep(1, e_ref, "R2 reference");

    // Candidate build with gaps and an ignored start pulse while busy (R9)
    gen(0, 4242); compute(); e_cand = tmp;
    run_build(0, 0, 1, 1);
    sweep(0, e_cand, "R4 candidate");
    sweep(1, e_ref, "R4 R9 reference held");

    // Feedback iteration, runs of equal colour (R5, R8, R6 no carry-over)
    gen(1, 777); compute(); e_cand = tmp;
    run_build(1, 0, 0, 0);
    sweep(0, e_cand, "R5 R8 iterate");
    sweep(1, e_ref, "R4 reference after iterate");

    // Single colour with gaps: whole weight in one bin saturates (R2, R1)
    gen(2, 1); compute(); e_cand = tmp;
    run_build(0, 0, 1, 0);
    @(negedge clk); rd_ref = 0; rd_bin = 9'd387;
    @(negedge clk);
    chk(rd_frac == 16'hFFFF, "R1 R2 bin {6,0,3} saturated", rd_frac, 65535);
    sweep(0, e_cand, "R8 single bin");

    // All weights zero (R3)
    gen(3, 99); compute(); e_cand = tmp;
    run_build(0, 0, 0, 0);
    sweep(0, e_cand, "R3 zero total");

    // Reference rebuild leaves candidate intact (R4)
    gen(1, 31337); compute(); e_ref = tmp;
    run_build(0, 1, 1, 0);
    sweep(1, e_ref, "R4 reference rebuild");
    sweep(0, e_cand, "R4 candidate untouched");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule